// File: doc/BRIEF.md
# YUV to RGB Colour Matrix with Inverse-Gamma Stage

This block turns one 4:4:4 YUV pixel per clock into 8-bit RGB. Luma is plain unsigned 8-bit. The two chroma inputs are offset binary, so 128 stands for zero. The matrix uses fixed coefficients held as integers over 64. After the matrix, each channel is clipped to 0..255. An optional table can then map each clipped value through a 1.4-power curve, which returns gamma-corrected video to a linear-light scale.

A pass-through mode serves monochrome and packed-YUV paths. In this mode the three input bytes leave the block unchanged. The pass-through and curve controls are sampled together with each valid pixel, so they can change from one pixel to the next. The pipeline has a fixed depth of three cycles, and idle gaps in the input stream are allowed.

Top module: `csc_gamma_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first pixel emerges, `rgbValid` is 0 and `rOut`, `gOut` and `bOut` are all 0.
- R2: Each cycle with `pixValid` high produces exactly one cycle with `rgbValid` high, three clock edges later. No other cycle has `rgbValid` high.
- R3: Let u = `uIn` − 128 and v = `vIn` − 128, and let f(p) = floor((p + 32) / 64). Before clipping, red is `yIn` + f(88·v).
- R4: Before clipping, green is `yIn` + f(−45·v − 22·u).
- R5: Before clipping, blue is `yIn` + f(111·u).
- R6: Each matrix result below 0 leaves as 0, and each result above 255 leaves as 255. Clipping is done before the curve stage.
- R7: When `linearOut` is 0 on a pixel that is not in pass-through, each clipped channel value c is replaced by round(255·(c/255)^1.4). The same table is used for all three channels.
- R8: When `linearOut` is 1 on a pixel that is not in pass-through, the clipped values are output without the curve.
- R9: When `passThru` is 1 on a pixel, the outputs are `rOut` = `vIn`, `gOut` = `yIn` and `bOut` = `uIn` of that pixel, unchanged. `linearOut` has no effect on such a pixel.
- R10: In cycles where `rgbValid` is 0, `rOut`, `gOut` and `bOut` keep the values of the most recent output pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | Input pixel is present this cycle |
| yIn | input | 8 | Luma, unsigned |
| uIn | input | 8 | Blue-difference chroma, offset binary (128 means zero) |
| vIn | input | 8 | Red-difference chroma, offset binary (128 means zero) |
| passThru | input | 1 | 1: skip the matrix and the curve for this pixel |
| linearOut | input | 1 | 1: skip the inverse-gamma curve for this pixel |
| rgbValid | output | 1 | Output pixel is present this cycle |
| rOut | output | 8 | Red, or V in pass-through |
| gOut | output | 8 | Green, or Y in pass-through |
| bOut | output | 8 | Blue, or U in pass-through |

## Verification
The latency assertion assumes that `pixValid` is low and known while reset is held. The hold and clipping assertions assume that the inputs carry no unknown values on the cycles when `pixValid` is high. The stimulus meets both assumptions. It drives every input on the falling edge, keeps `pixValid` low throughout reset, and always gives the data and control inputs defined values, including in idle cycles. The stimulus also deliberately mixes idle gaps, pass-through pixels and curve toggling within the stream. This checks that the per-pixel controls stay aligned with their own samples.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W   = 8;
  localparam int FRAC_W  = 6;
  localparam int PROD_W  = 18;
  localparam int SUM_W   = 11;
  localparam int LUT_N   = 1 << PIX_W;
  localparam int PIX_MAX = LUT_N - 1;
  localparam int CHROMA_ZERO = 1 << (PIX_W - 1);

  localparam int COEF_RV = 88;
  localparam int COEF_GV = 45;
  localparam int COEF_GU = 22;
  localparam int COEF_BU = 111;
  localparam int ROUND_K = 1 << (FRAC_W - 1);

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic passS3;
    logic linS3;
  } cscStrobe_t;

  function automatic logic [PIX_W-1:0] gammaEntry(input int code);
    real frac;
    real lvl;
    frac = real'(code) / real'(PIX_MAX);
    lvl  = real'(PIX_MAX) * (frac ** 1.4);
    return PIX_W'($rtoi(lvl + 0.5));
  endfunction
endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pixValid,
  input  logic       passThru,
  input  logic       linearOut,
  output cscStrobe_t stb,
  output logic       rgbValid
);
  logic vldS1, vldS2, vldS3;
  logic passS1, passS2, linS1, linS2;
  logic [1:0] warmCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vldS1 <= 1'b0;
      vldS2 <= 1'b0;
      vldS3 <= 1'b0;
    end else begin
      vldS1 <= pixValid;
      vldS2 <= vldS1;
      vldS3 <= vldS2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      passS1 <= 1'b0;
      linS1  <= 1'b0;
      passS2 <= 1'b0;
      linS2  <= 1'b0;
    end else begin
      if (pixValid) begin
        passS1 <= passThru;
        linS1  <= linearOut;
      end
      if (vldS1) begin
        passS2 <= passS1;
        linS2  <= linS1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  always_comb begin
    stb.ld1    = pixValid;
    stb.ld2    = vldS1;
    stb.ld3    = vldS2;
    stb.passS3 = passS2;
    stb.linS3  = linS2;
  end

  assign rgbValid = vldS3;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warmCnt == 2'd3) |-> (rgbValid == $past(pixValid, 3))); // R2
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cscStrobe_t       stb,
  input  logic [PIX_W-1:0] yIn,
  input  logic [PIX_W-1:0] uIn,
  input  logic [PIX_W-1:0] vIn,
  output logic [PIX_W-1:0] rOut,
  output logic [PIX_W-1:0] gOut,
  output logic [PIX_W-1:0] bOut
);
  localparam logic signed [PROD_W-1:0] K_RV  = PROD_W'(COEF_RV);
  localparam logic signed [PROD_W-1:0] K_GV  = PROD_W'(COEF_GV);
  localparam logic signed [PROD_W-1:0] K_GU  = PROD_W'(COEF_GU);
  localparam logic signed [PROD_W-1:0] K_BU  = PROD_W'(COEF_BU);
  localparam logic signed [PROD_W-1:0] K_RND = PROD_W'(ROUND_K);
  localparam logic [PIX_W:0] ZERO_OFF = (PIX_W+1)'(CHROMA_ZERO);

  // Stage 1: capture, remove chroma offset
  logic [PIX_W-1:0] yS1, uRawS1, vRawS1;
  logic signed [PIX_W:0] uS1, vS1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yS1 <= '0; uRawS1 <= '0; vRawS1 <= '0; uS1 <= '0; vS1 <= '0;
    end else if (stb.ld1) begin
      yS1    <= yIn;
      uRawS1 <= uIn;
      vRawS1 <= vIn;
      uS1    <= signed'({1'b0, uIn} - ZERO_OFF);
      vS1    <= signed'({1'b0, vIn} - ZERO_OFF);
    end
  end

  // Stage 2: products, rounding, luma add
  logic signed [PROD_W-1:0] uExt, vExt, yExt, rAcc, gAcc, bAcc;
  logic signed [SUM_W-1:0] rS2, gS2, bS2;
  logic [PIX_W-1:0] yRawS2, uRawS2, vRawS2;

  always_comb begin
    uExt = PROD_W'(uS1);
    vExt = PROD_W'(vS1);
    yExt = PROD_W'(signed'({1'b0, yS1}));
    rAcc = yExt + ((K_RV * vExt + K_RND) >>> FRAC_W);
    gAcc = yExt + ((K_RND - K_GV * vExt - K_GU * uExt) >>> FRAC_W);
    bAcc = yExt + ((K_BU * uExt + K_RND) >>> FRAC_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rS2 <= '0; gS2 <= '0; bS2 <= '0;
      yRawS2 <= '0; uRawS2 <= '0; vRawS2 <= '0;
    end else if (stb.ld2) begin
      rS2    <= SUM_W'(rAcc);
      gS2    <= SUM_W'(gAcc);
      bS2    <= SUM_W'(bAcc);
      yRawS2 <= yS1;
      uRawS2 <= uRawS1;
      vRawS2 <= vRawS1;
    end
  end

  // Stage 3: clip, curve, pass-through select
  logic [PIX_W-1:0] curveRom [LUT_N];
  for (genvar gi = 0; gi < LUT_N; gi++) begin : g_rom
    localparam logic [PIX_W-1:0] ENTRY = gammaEntry(gi);
    assign curveRom[gi] = ENTRY;
  end

  function automatic logic [PIX_W-1:0] clip(input logic signed [SUM_W-1:0] s);
    if (s < 0) return '0;
    else if (s > SUM_W'(PIX_MAX)) return PIX_W'(PIX_MAX);
    else return s[PIX_W-1:0];
  endfunction

  logic [PIX_W-1:0] rClip, gClip, bClip, rNext, gNext, bNext;

  always_comb begin
    rClip = clip(rS2);
    gClip = clip(gS2);
    bClip = clip(bS2);
    if (stb.passS3) begin
      rNext = vRawS2; gNext = yRawS2; bNext = uRawS2;
    end else if (stb.linS3) begin
      rNext = rClip; gNext = gClip; bNext = bClip;
    end else begin
      rNext = curveRom[rClip]; gNext = curveRom[gClip]; bNext = curveRom[bClip];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rOut <= '0; gOut <= '0; bOut <= '0;
    end else if (stb.ld3) begin
      rOut <= rNext; gOut <= gNext; bOut <= bNext;
    end
  end

  AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.ld3 && !stb.passS3 && (gS2 < 0)) |=> (gOut == '0)); // R6
  AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.ld3 && !stb.passS3 && (bS2 > SUM_W'(PIX_MAX))) |=> (bOut == PIX_W'(PIX_MAX))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.ld3 |=> ($stable(rOut) && $stable(gOut) && $stable(bOut))); // R10
endmodule

// File: rtl/csc_gamma_top.sv
module csc_gamma_top
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] yIn,
  input  logic [PIX_W-1:0] uIn,
  input  logic [PIX_W-1:0] vIn,
  input  logic             passThru,
  input  logic             linearOut,
  output logic             rgbValid,
  output logic [PIX_W-1:0] rOut,
  output logic [PIX_W-1:0] gOut,
  output logic [PIX_W-1:0] bOut
);
  cscStrobe_t stb;

  csc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .passThru(passThru),
    .linearOut(linearOut), .stb(stb), .rgbValid(rgbValid)
  );

  csc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .yIn(yIn), .uIn(uIn), .vIn(vIn),
    .rOut(rOut), .gOut(gOut), .bOut(bOut)
  );
endmodule

// File: tb/csc_gamma_top_bench.sv
`timescale 1ns/1ps
module csc_gamma_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pixValid = 1'b0, passThru = 1'b0, linearOut = 1'b0;
  logic [7:0] yIn = '0, uIn = '0, vIn = '0;
  logic rgbValid;
  logic [7:0] rOut, gOut, bOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [24:0] expQ[$];
  logic [7:0] lastR = '0, lastG = '0, lastB = '0;

  always #4 clk = ~clk;

  csc_gamma_top u_csc_gamma_top (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .yIn(yIn), .uIn(uIn), .vIn(vIn),
    .passThru(passThru), .linearOut(linearOut), .rgbValid(rgbValid),
    .rOut(rOut), .gOut(gOut), .bOut(bOut)
  );

  function automatic int fdiv(input int p);
    return $rtoi($floor((real'(p) + 32.0) / 64.0));
  endfunction

  function automatic int clamp(input int x);
    return (x < 0) ? 0 : ((x > 255) ? 255 : x);
  endfunction

  function automatic int curve(input int c);
    return $rtoi(255.0 * $pow(real'(c) / 255.0, 1.4) + 0.5);
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkOut();
    logic [24:0] e;
    if (expQ.size() < 3) return;
    e = expQ.pop_front();
    cmp("R2 valid", int'(rgbValid), int'(e[24]));
    if (e[24]) begin
      cmp("R3/R6/R7/R8/R9 red", rOut, e[23:16]);
      cmp("R4/R6/R7/R8/R9 green", gOut, e[15:8]);
      cmp("R5/R6/R7/R8/R9 blue", bOut, e[7:0]);
      lastR = e[23:16]; lastG = e[15:8]; lastB = e[7:0];
    end else begin
      cmp("R10 hold red", rOut, lastR);
      cmp("R10 hold green", gOut, lastG);
      cmp("R10 hold blue", bOut, lastB);
    end
  endtask

  task automatic drive(input bit v, input int y, input int u, input int w,
                       input bit pt, input bit lin);
    int r, g, b;
    @(negedge clk);
    checkOut();
    pixValid = v; yIn = 8'(y); uIn = 8'(u); vIn = 8'(w);
    passThru = pt; linearOut = lin;
    if (pt) begin
      r = w; g = y; b = u; // R9
    end else begin
      r = clamp(y + fdiv(88 * (w - 128)));                       // R3 R6
      g = clamp(y + fdiv(-45 * (w - 128) - 22 * (u - 128)));     // R4 R6
      b = clamp(y + fdiv(111 * (u - 128)));                      // R5 R6
      if (!lin) begin r = curve(r); g = curve(g); b = curve(b); end // R7 R8
    end
    expQ.push_back({v, 8'(r), 8'(g), 8'(b)});
  endtask

  initial begin
    #3;
    // R1: reset state
    cmp("R1 reset valid", int'(rgbValid), 0);
    cmp("R1 reset red", rOut, 0);
    cmp("R1 reset green", gOut, 0);
    cmp("R1 reset blue", bOut, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) expQ.push_back(25'd0);
    drive(1, 100, 128, 128, 0, 1);   // grey, linear
    drive(1, 100, 128, 128, 0, 0);   // grey, curve
    drive(1, 255, 128, 255, 0, 1);   // red clips high
    drive(0, 0, 0, 0, 0, 0);         // gap
    drive(1, 0, 0, 128, 0, 1);       // blue clips low
    drive(1, 0, 255, 255, 0, 1);     // green clips low
    drive(1, 255, 0, 0, 0, 0);       // green clips high, curve
    drive(1, 37, 200, 90, 1, 0);     // pass-through ignores curve
    drive(1, 37, 200, 90, 1, 1);     // pass-through
    drive(0, 1, 2, 3, 1, 1);         // idle with junk
    drive(0, 9, 9, 9, 0, 0);
    drive(1, 16, 128, 128, 0, 0);
    drive(1, 235, 240, 16, 0, 1);
    drive(1, 81, 90, 240, 0, 0);
    for (int i = 0; i < 600; i++) begin
      drive(($urandom % 4) != 0, $urandom % 256, $urandom % 256, $urandom % 256,
            ($urandom % 6) == 0, ($urandom % 2) == 1);
    end
    repeat (5) drive(0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule